// File: doc/BRIEF.md
# Retire Thread Arbiter

In a multithreaded out-of-order core, only one hardware thread may retire instructions in a given cycle. This block makes that choice. Each cycle it looks at which threads are running, whether each thread's oldest in-flight entry is ready to retire, and whether each thread's reorder storage holds anything at all. It also sees the sequence number of each thread's oldest entry. From these it names one thread, or it reports that no thread may retire this cycle.

A policy input switches between two schemes while the block runs. The first is a rotating priority list: the first thread in the list with a ready head wins, and the winner then drops to the back of the list. The second is an age scheme: among threads with a ready, non-empty head, the smallest sequence number wins. When exactly one thread is running, the policy is bypassed. That thread is named whenever its storage is not empty.

The choice is combinational from the current inputs. Only the rotating list is held in registers, and it advances on the clock edge.

Top module: `retire_thread_arbiter`

## Requirements
- R1: `policy_sel` = 0 selects the rotating scheme and `policy_sel` = 1 selects the age scheme. `grant_valid` and `grant_tid` follow the inputs in the same cycle, with no register in between.
- R2: In the rotating scheme with two or more threads active, the grant goes to the first thread in the priority list that is active and has `head_ready` set.
- R3: In the age scheme with two or more threads active, the grant goes to the thread with the smallest `head_seq` value, compared as an unsigned number. Only threads that are active, have `head_ready` set and have `buf_empty` clear take part.
- R4: In the age scheme, when several candidate threads share the smallest sequence number, the one with the lowest index wins.
- R5: When no thread qualifies, `grant_valid` is 0 and `grant_tid` is 0.
- R6: When exactly one thread is active, that thread is granted whenever its `buf_empty` is 0, whatever `head_ready` and `policy_sel` say. When its `buf_empty` is 1, there is no grant.
- R7: A thread whose `thread_active` bit is 0 is never granted, even when its `head_ready` is set.
- R8: After a clock edge at which `grant_valid` was 1 with `policy_sel` = 0, the granted thread is at the last place of the priority list. The other threads keep their relative order.
- R9: A clock edge without a grant, or with `policy_sel` = 1, leaves the priority list unchanged.
- R10: `rst_n` low resets the list at once, without waiting for a clock edge, to ascending order: thread 0 first, thread NUM_THREADS-1 last.
- R11: Thread t's sequence number occupies bits [t*SEQ_W +: SEQ_W] of `head_seq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_sel | input | 1 | 0 = rotating list, 1 = oldest ready head |
| thread_active | input | NUM_THREADS | Per-thread running flag |
| head_ready | input | NUM_THREADS | Per-thread oldest entry ready to retire |
| buf_empty | input | NUM_THREADS | Per-thread reorder storage empty |
| head_seq | input | NUM_THREADS*SEQ_W | Packed per-thread oldest sequence numbers |
| grant_valid | output | 1 | A thread is chosen this cycle |
| grant_tid | output | $clog2(NUM_THREADS) | Chosen thread index, 0 when no grant |

## Verification
The bench builds the block with four threads and an 8-bit sequence field. With four threads, every shape of the active mask can be reached, including the single-thread bypass. A narrow sequence field makes equal head sequence numbers common under random stimulus, so the tie rule is exercised often and not only in a directed case. A reference model keeps the priority list as a queue and is compared every cycle. This covers long chains of rotations, policy switches in the middle of a run, and a reset that arrives between clock edges.

// File: rtl/rta_pkg.sv
package rta_pkg;

  typedef enum logic {
    POL_ROTATE = 1'b0,
    POL_OLDEST = 1'b1
  } rta_policy_e;

  // width of a thread index, never below one bit
  function automatic int tid_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rta_rr_pick.sv
// Walks the priority list from the front and returns the first eligible thread.
module rta_rr_pick #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS-1:0][TID_W-1:0] order,
  input  logic [NUM_THREADS-1:0]            elig,
  output logic                              hit,
  output logic [TID_W-1:0]                  tid
);

  always_comb begin
    hit = 1'b0;
    tid = '0;
    // scanning from the back lets the front-most match overwrite the rest
    for (int p = NUM_THREADS - 1; p >= 0; p--) begin
      if (elig[order[p]]) begin
        hit = 1'b1;
        tid = order[p];
      end
    end
  end

endmodule

// File: rtl/rta_age_pick.sv
// Returns the eligible thread with the smallest sequence number; lowest index on ties.
module rta_age_pick #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0] seq,
  input  logic [NUM_THREADS-1:0]            elig,
  output logic                              hit,
  output logic [TID_W-1:0]                  tid
);

  logic [SEQ_W-1:0] best;

  always_comb begin
    hit  = 1'b0;
    tid  = '0;
    best = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      // strict less-than keeps the earlier (lower) index on equal values
      if (elig[t] && (!hit || (seq[t] < best))) begin
        hit  = 1'b1;
        tid  = TID_W'(t);
        best = seq[t];
      end
    end
  end

endmodule

// File: rtl/rta_order_reg.sv
// Holds the rotating priority list; a granted thread moves to the back.
module rta_order_reg #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              upd,
  input  logic [TID_W-1:0]                  gtid,
  output logic [NUM_THREADS-1:0][TID_W-1:0] order_q
);

  logic [NUM_THREADS-1:0][TID_W-1:0] order_d;
  int                                pos;

  // next-state: locate the granted thread and close the gap it leaves
  always_comb begin
    pos = 0;
    for (int p = NUM_THREADS - 1; p >= 0; p--) begin
      if (order_q[p] == gtid) pos = p;
    end
    order_d = order_q;
    for (int p = 0; p < NUM_THREADS - 1; p++) begin
      if (p >= pos) order_d[p] = order_q[p+1];
    end
    order_d[NUM_THREADS-1] = gtid;
  end

  // register with explicit enable; reset gives ascending order
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_THREADS; p++) order_q[p] <= TID_W'(p);
    end else if (upd) begin
      order_q <= order_d;
    end
  end

endmodule

// File: rtl/retire_thread_arbiter.sv
module retire_thread_arbiter
  import rta_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                policy_sel,
  input  logic [NUM_THREADS-1:0]              thread_active,
  input  logic [NUM_THREADS-1:0]              head_ready,
  input  logic [NUM_THREADS-1:0]              buf_empty,
  input  logic [NUM_THREADS*SEQ_W-1:0]        head_seq,
  output logic                                grant_valid,
  output logic [tid_width(NUM_THREADS)-1:0]   grant_tid
);

  localparam int TID_W = tid_width(NUM_THREADS);

  logic [NUM_THREADS-1:0][SEQ_W-1:0] seq_arr;
  logic [NUM_THREADS-1:0][TID_W-1:0] order_q;
  logic [NUM_THREADS-1:0]            rr_elig;
  logic [NUM_THREADS-1:0]            age_elig;
  logic                              rr_hit;
  logic                              age_hit;
  logic [TID_W-1:0]                  rr_tid;
  logic [TID_W-1:0]                  age_tid;
  logic                              solo;
  logic [TID_W-1:0]                  solo_tid;
  int                                act_cnt;
  rta_policy_e                       pol;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_seq
    assign seq_arr[t] = head_seq[t*SEQ_W +: SEQ_W];
  end

  assign pol      = rta_policy_e'(policy_sel);
  assign rr_elig  = thread_active & head_ready;
  assign age_elig = thread_active & head_ready & ~buf_empty;

  // single-thread bypass detection
  always_comb begin
    act_cnt  = 0;
    solo_tid = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (thread_active[t]) begin
        act_cnt  = act_cnt + 1;
        solo_tid = TID_W'(t);
      end
    end
    solo = (act_cnt == 1);
  end

  rta_rr_pick #(
    .NUM_THREADS (NUM_THREADS),
    .TID_W       (TID_W)
  ) u_rr (
    .order (order_q),
    .elig  (rr_elig),
    .hit   (rr_hit),
    .tid   (rr_tid)
  );

  rta_age_pick #(
    .NUM_THREADS (NUM_THREADS),
    .SEQ_W       (SEQ_W),
    .TID_W       (TID_W)
  ) u_age (
    .seq  (seq_arr),
    .elig (age_elig),
    .hit  (age_hit),
    .tid  (age_tid)
  );

  always_comb begin
    grant_valid = 1'b0;
    grant_tid   = '0;
    if (solo) begin
      grant_valid = !buf_empty[solo_tid];
      grant_tid   = grant_valid ? solo_tid : '0;
    end else if (pol == POL_OLDEST) begin
      grant_valid = age_hit;
      grant_tid   = age_tid;
    end else begin
      grant_valid = rr_hit;
      grant_tid   = rr_tid;
    end
  end

  rta_order_reg #(
    .NUM_THREADS (NUM_THREADS),
    .TID_W       (TID_W)
  ) u_order (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (grant_valid && (pol == POL_ROTATE)),
    .gtid    (grant_tid),
    .order_q (order_q)
  );

endmodule

// File: rtl/rta_chk.sv
module rta_chk #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   policy_sel,
  input logic [NUM_THREADS-1:0] thread_active,
  input logic [NUM_THREADS-1:0] head_ready,
  input logic [NUM_THREADS-1:0] buf_empty,
  input logic                   grant_valid,
  input logic [TID_W-1:0]       grant_tid
);

  // R7
  inactive_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> thread_active[grant_tid]);

  // R2
  rr_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !policy_sel && $countones(thread_active) > 1) |-> head_ready[grant_tid]);

  // R3
  age_needs_content_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && policy_sel && $countones(thread_active) > 1)
      |-> (head_ready[grant_tid] && !buf_empty[grant_tid]));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant_tid == '0));

  // R5
  none_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(thread_active) > 1 && (thread_active & head_ready) == '0) |-> !grant_valid);

  // R6
  solo_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(thread_active) == 1)
      |-> (grant_valid == ((thread_active & buf_empty) == '0)));

endmodule

bind retire_thread_arbiter rta_chk #(
  .NUM_THREADS (NUM_THREADS),
  .TID_W       (TID_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .policy_sel    (policy_sel),
  .thread_active (thread_active),
  .head_ready    (head_ready),
  .buf_empty     (buf_empty),
  .grant_valid   (grant_valid),
  .grant_tid     (grant_tid)
);

// File: tb/sim_retire_thread_arbiter.sv
module sim_retire_thread_arbiter;

  localparam int NT = 4;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          policy_sel = 1'b0;
  logic [NT-1:0] thread_active = '0;
  logic [NT-1:0] head_ready = '0;
  logic [NT-1:0] buf_empty = '0;
  logic [NT*SW-1:0] head_seq = '0;
  logic          grant_valid;
  logic [1:0]    grant_tid;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int q[$];

  always #4 clk = ~clk;

  retire_thread_arbiter #(.NUM_THREADS(NT), .SEQ_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
    .thread_active(thread_active), .head_ready(head_ready),
    .buf_empty(buf_empty), .head_seq(head_seq),
    .grant_valid(grant_valid), .grant_tid(grant_tid)
  );

  function automatic int seq_of(int t);
    return int'(head_seq[t*SW +: SW]); // R11 field position
  endfunction

  task automatic model(output bit v, output int t, output string tag);
    int cnt = 0;
    int only = 0;
    v = 0; t = 0; tag = "";
    for (int i = 0; i < NT; i++) if (thread_active[i]) begin cnt++; only = i; end
    if (cnt == 1) begin
      tag = "R6";
      v = !buf_empty[only];
      t = v ? only : 0;
    end else if (!policy_sel) begin
      tag = "R2";
      foreach (q[k]) if (!v && thread_active[q[k]] && head_ready[q[k]]) begin
        v = 1; t = q[k];
      end
    end else begin
      int best = 0;
      tag = "R3";
      for (int i = 0; i < NT; i++)
        if (thread_active[i] && head_ready[i] && !buf_empty[i] && (!v || seq_of(i) < best)) begin
          v = 1; t = i; best = seq_of(i);
        end
    end
    if (!v) tag = {tag, "/R5"};
  endtask

  task automatic check(string tag, bit ev, int et);
    total++;
    if (grant_valid !== ev || int'(grant_tid) !== et) begin
      bad++;
      $display("FAIL %s: got valid=%0d tid=%0d expected valid=%0d tid=%0d",
               tag, grant_valid, grant_tid, ev, et);
    end
  endtask

  // inputs are driven at negedge, compared 2 ns later, model advanced at posedge
  task automatic step(string extra);
    bit v; int t; string tag;
    #2;
    model(v, t, tag);
    check({tag, " ", extra}, v, t);
    @(posedge clk);
    if (v && !policy_sel) begin // R8 / R9 model
      foreach (q[k]) if (q[k] == t) begin q.delete(k); break; end
      q.push_back(t);
    end
    @(negedge clk);
  endtask

  task automatic drive(bit p, logic [3:0] a, logic [3:0] r, logic [3:0] e,
                       int s0, int s1, int s2, int s3);
    policy_sel = p; thread_active = a; head_ready = r; buf_empty = e;
    head_seq = {SW'(s3), SW'(s2), SW'(s1), SW'(s0)};
  endtask

  task automatic reset_model();
    q = {};
    for (int i = 0; i < NT; i++) q.push_back(i);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    reset_model();
    @(negedge clk); @(negedge clk);
    #1; check("R10 reset idle", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: ascending order after reset, R8: rotation
    drive(0, 4'hF, 4'hF, 4'h0, 1, 2, 3, 4);
    step("R10 first after reset");
    step("R8 rotate to 1");
    step("R8 rotate to 2");
    // R7: inactive threads ignored even when ready
    drive(0, 4'b0101, 4'hF, 4'h0, 0, 0, 0, 0);
    step("R7 inactive ready");
    step("R7 inactive ready again");
    // R4: tie goes to lower index
    drive(1, 4'hF, 4'b1010, 4'h0, 5, 5, 5, 5);
    step("R4 tie");
    // R3 with R11: smallest in the highest field
    drive(1, 4'hF, 4'hF, 4'b0001, 0, 9, 7, 3);
    step("R3 R11 oldest");
    // R9: age mode grants leave list alone, then switch back
    drive(0, 4'hF, 4'hF, 4'h0, 0, 0, 0, 0);
    step("R9 R1 after age mode");
    // R6: single active thread bypass
    drive(1, 4'b0100, 4'b0000, 4'b0000, 0, 0, 0, 0);
    step("R6 solo not ready");
    drive(0, 4'b0100, 4'b0100, 4'b0100, 0, 0, 0, 0);
    step("R6 solo empty");
    // R5: nothing qualifies
    drive(0, 4'hF, 4'h0, 4'h0, 0, 0, 0, 0);
    step("R5 none");
    drive(1, 4'hF, 4'hF, 4'hF, 0, 0, 0, 0);
    step("R5 all empty");

    // random phase: narrow sequence field makes ties frequent
    for (int n = 0; n < 800; n++) begin
      drive($urandom_range(0, 1), 4'($urandom), 4'($urandom), 4'($urandom & $urandom),
            $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
      step("random");
    end

    // R10: asynchronous reset between edges restores ascending order
    drive(0, 4'hF, 4'hF, 4'h0, 0, 0, 0, 0);
    #1; rst_n = 1'b0; reset_model();
    #1; check("R10 async reset idle", 1, 0);
    @(negedge clk); rst_n = 1'b1;
    step("R10 after async reset");
    step("R8 rotate after reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule